// File: doc/BRIEF.md
# Vacuum Fluorescent Display Scan and Brightness Sequencer

This block produces the time-multiplexed enable pattern for a grid/segment vacuum fluorescent display. It cycles through a programmable number of timing slots, from 5 to 16. In each slot it fetches that slot's bit pattern from an external display RAM and lights exactly one grid line. It also keeps every display line dark for a programmable leading part of the slot, and that dark interval sets the brightness. The 25 enables are meant to feed high-voltage drivers. Those drivers, and the serial front end that writes the configuration and the RAM, sit outside this block.

Configuration arrives as static register values: a slot-count code, a 2-bit brightness code, a display enable, a first-digit-pin code, a pin-mode code and three port bits. The pin-mode code decides whether the top three lines scan as grids or act as plain output ports. Port lines follow the port bits whether or not the display is scanning. The block issues a byte address to a synchronous RAM with one cycle of read latency and captures the returned word early in the slot, while the lines are still dark. This hides the read latency entirely.

Top module: `vfd_scan_seq`

## Requirements
- R1: While `rst` is high, `out_en` is all zeros from the first rising edge on.
- R2: Each slot lasts `SLOT_CYCLES` clocks. Slots run from index n-1 down to 0 and the sequence then restarts at n-1 with no idle cycle. After reset is released, the first slot is index n-1. `out_en` lags the slot state by one clock.
- R3: Slot-count code c (4 bits) gives n = 16 - c for c from 0 to 11, and n = 5 for c from 12 to 15. A new code is only sampled at the wrap from index 0.
- R4: During slot index k, `ram_addr` is 4*k. The word read for that slot is captured one clock after the address appears. Bit i of that word is the pattern for line i.
- R5: Brightness code 2'b11, 2'b10, 2'b01 and 2'b00 lights 15, 6, 4 and 3 sixteenths of the slot respectively. Display lines stay dark for the first `SLOT_CYCLES`*(16-m)/16 clocks of each slot, where m is the lit count, and follow their data for the rest of the slot.
- R6: First-digit code d gives first grid line F = 18 - d for d from 0 to 10, and F = 8 for d above 10. Non-port lines below F take their RAM pattern bit.
- R7: In slot index k, non-port lines at or above F are all low except line F + k, which is high when lit. Nothing is lit among them when F + k exceeds 24 or lands on a port.
- R8: Pin-mode code 2'b00 makes line 24 a port. 2'b01 makes lines 24 and 23 ports. 2'b10 makes lines 24, 23 and 22 ports. 2'b11 makes no line a port.
- R9: A port line drives a port bit (line 24 from bit 0, line 23 from bit 1, line 22 from bit 2) one clock after the bit is applied. This holds in every slot phase and whether the display is on or off.
- R10: With the display enable low, every non-port line is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slots | input | 4 | Slot-count code |
| cfg_duty | input | 2 | Brightness code |
| cfg_disp_on | input | 1 | Display enable |
| cfg_dig_start | input | 5 | First-digit-line code |
| cfg_pin_mode | input | 2 | Grid/port selection for the top three lines |
| cfg_port | input | 3 | Port bits |
| ram_rdata | input | 25 | Display RAM read data, one cycle after the address |
| ram_addr | output | 6 | Display RAM byte address of the current slot's group |
| out_en | output | 25 | Line enables, line 0 in bit 0 |

## Verification
The hardest case to reach is a slot-count change that lands in the middle of a scan. The block must finish the old sequence down to index 0 before it adopts the new count. The stimulus rewrites the code at points that are not aligned to any slot, including an out-of-range code that clamps to five slots. A cycle-accurate reference then exposes any early reload through a wrong address or a grid on the wrong line. A second hard case is a grid index that runs past line 24 or onto a port. This is reached by combining sixteen slots with a high first-digit line and every pin mode.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    localparam int NUM_PINS     = 25;
    localparam int PORT_PINS    = 3;
    localparam int MAX_SLOTS    = 16;
    localparam int MIN_SLOTS    = 5;
    localparam int TOP_DIGIT    = 18;
    localparam int MAX_DIG_CODE = 10;
    localparam int IDX_W        = $clog2(MAX_SLOTS);
    localparam int PIN_W        = $clog2(NUM_PINS);

    typedef logic [IDX_W-1:0] slot_idx_t;
    typedef logic [PIN_W-1:0] pin_t;

    typedef enum logic [1:0] {
        DUTY_3  = 2'b00,
        DUTY_4  = 2'b01,
        DUTY_6  = 2'b10,
        DUTY_15 = 2'b11
    } duty_e;

    typedef enum logic [1:0] {
        PM_ONE   = 2'b00,
        PM_TWO   = 2'b01,
        PM_THREE = 2'b10,
        PM_NONE  = 2'b11
    } pinmode_e;

    typedef struct packed {
        logic [NUM_PINS-1:0] port_mask;
        logic [NUM_PINS-1:0] port_val;
        pin_t                first_pin;
    } pin_cfg_t;

    // Highest slot index of a scan for a given count code.
    function automatic slot_idx_t last_index(input logic [IDX_W-1:0] code);
        if (int'(code) > MAX_SLOTS - MIN_SLOTS)
            return slot_idx_t'(MIN_SLOTS - 1);
        return slot_idx_t'(MAX_SLOTS - 1 - int'(code));
    endfunction

    // Lit sixteenths of a slot.
    function automatic logic [4:0] on_sixteenths(input duty_e d);
        case (d)
            DUTY_15: return 5'd15;
            DUTY_6:  return 5'd6;
            DUTY_4:  return 5'd4;
            default: return 5'd3;
        endcase
    endfunction

    function automatic pin_t first_digit(input logic [4:0] code);
        if (int'(code) > MAX_DIG_CODE)
            return pin_t'(TOP_DIGIT - MAX_DIG_CODE);
        return pin_t'(TOP_DIGIT - int'(code));
    endfunction

    function automatic int port_count(input pinmode_e m);
        case (m)
            PM_ONE:   return 1;
            PM_TWO:   return 2;
            PM_THREE: return 3;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_CYCLES = 768,
    localparam int PH_W = $clog2(SLOT_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] slots_code,
    output slot_idx_t        slot_idx,
    output logic [PH_W-1:0]  phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYCLES - 1);

    // Reset parks the counter on the last phase of index 0, so the first
    // active edge performs an ordinary wrap and samples the count code.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_LAST;
            slot_idx <= '0;
        end else if (phase == PH_LAST) begin
            phase    <= '0;
            slot_idx <= (slot_idx == '0) ? last_index(slots_code)
                                         : slot_idx - 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/vfd_pin_map.sv
module vfd_pin_map
    import vfd_scan_pkg::*;
(
    input  logic [4:0]           dig_start,
    input  pinmode_e             pin_mode,
    input  logic [PORT_PINS-1:0] port_data,
    output pin_cfg_t             pins
);
    logic [NUM_PINS-1:0] mask;
    logic [NUM_PINS-1:0] val;
    int                  n_ports;

    assign n_ports = port_count(pin_mode);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i >= NUM_PINS - PORT_PINS) begin : g_port
            localparam int PI = NUM_PINS - 1 - i;
            assign mask[i] = (PI < n_ports);
            assign val[i]  = port_data[PI];
        end else begin : g_disp
            assign mask[i] = 1'b0;
            assign val[i]  = 1'b0;
        end
    end

    assign pins.port_mask = mask;
    assign pins.port_val  = val;
    assign pins.first_pin = first_digit(dig_start);

endmodule

// File: rtl/vfd_scan_drive.sv
module vfd_scan_drive
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_CYCLES = 768,
    localparam int PH_W = $clog2(SLOT_CYCLES)
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_idx_t           slot_idx,
    input  logic [PH_W-1:0]     phase,
    input  duty_e               duty,
    input  logic                disp_on,
    input  pin_cfg_t            pins,
    input  logic [NUM_PINS-1:0] ram_rdata,
    output logic [NUM_PINS-1:0] out_en
);
    localparam int TICK = SLOT_CYCLES / 16;
    localparam int GP_W = PIN_W + 1;

    logic [NUM_PINS-1:0] pattern;
    logic [NUM_PINS-1:0] next_out;
    logic [PH_W-1:0]     off_cycles;
    logic                lit;
    logic [GP_W-1:0]     grid_pin;

    // The RAM word for this slot arrives while phase is 1; the blank lead
    // is at least two clocks long, so it is always in place when lit.
    always_ff @(posedge clk) begin
        if (rst)
            pattern <= '0;
        else if (phase == PH_W'(1))
            pattern <= ram_rdata;
    end

    always_comb begin
        off_cycles = PH_W'(TICK * (16 - int'(on_sixteenths(duty))));
        lit        = disp_on && (phase >= off_cycles);
        grid_pin   = GP_W'(pins.first_pin) + GP_W'(slot_idx);
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
        assign next_out[i] =
            pins.port_mask[i]            ? pins.port_val[i] :
            !lit                         ? 1'b0 :
            (pin_t'(i) >= pins.first_pin) ? (grid_pin == GP_W'(i)) :
                                           pattern[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_en <= '0;
        else
            out_en <= next_out;
    end

endmodule

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_CYCLES = 768
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           cfg_slots,
    input  logic [1:0]           cfg_duty,
    input  logic                 cfg_disp_on,
    input  logic [4:0]           cfg_dig_start,
    input  logic [1:0]           cfg_pin_mode,
    input  logic [2:0]           cfg_port,
    input  logic [24:0]          ram_rdata,
    output logic [5:0]           ram_addr,
    output logic [24:0]          out_en
);
    localparam int PH_W = $clog2(SLOT_CYCLES);

    slot_idx_t       slot_idx;
    logic [PH_W-1:0] phase;
    pin_cfg_t        pins;

    vfd_scan_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .slots_code (cfg_slots),
        .slot_idx   (slot_idx),
        .phase      (phase)
    );

    vfd_pin_map u_pin_map (
        .dig_start (cfg_dig_start),
        .pin_mode  (pinmode_e'(cfg_pin_mode)),
        .port_data (cfg_port),
        .pins      (pins)
    );

    vfd_scan_drive #(.SLOT_CYCLES(SLOT_CYCLES)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .slot_idx  (slot_idx),
        .phase     (phase),
        .duty      (duty_e'(cfg_duty)),
        .disp_on   (cfg_disp_on),
        .pins      (pins),
        .ram_rdata (ram_rdata),
        .out_en    (out_en)
    );

    assign ram_addr = {slot_idx, 2'b00};

endmodule

// File: rtl/vfd_scan_seq_chk.sv
module vfd_scan_seq_chk
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_CYCLES = 768,
    localparam int PH_W = $clog2(SLOT_CYCLES)
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] out_en,
    input logic [5:0]          ram_addr,
    input logic [PH_W-1:0]     phase,
    input slot_idx_t           slot_idx,
    input logic [NUM_PINS-1:0] port_mask,
    input logic [NUM_PINS-1:0] port_val,
    input pin_t                first_pin,
    input logic                disp_on
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYCLES - 1);

    logic [NUM_PINS-1:0] dig_mask;
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++)
            dig_mask[i] = (pin_t'(i) >= first_pin) && !port_mask[i];
    end

    p_reset_dark_r1: assert property (@(posedge clk)
        rst |=> (out_en == '0));

    p_hold_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_LAST) |=> $stable(slot_idx));

    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_LAST) && (slot_idx != '0)) |=> (slot_idx == $past(slot_idx) - 1'b1));

    p_addr_tracks_slot_r4: assert property (@(posedge clk) disable iff (rst)
        ram_addr[5:2] == slot_idx && ram_addr[1:0] == 2'b00);

    p_blank_lead_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_W'(1)) |-> ((out_en & ~$past(port_mask)) == '0));

    p_single_grid_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(out_en & $past(dig_mask)) <= 1));

    p_port_follow_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((out_en & $past(port_mask)) == ($past(port_val) & $past(port_mask))));

    p_dark_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !disp_on |=> ((out_en & ~$past(port_mask)) == '0));

endmodule

bind vfd_scan_seq vfd_scan_seq_chk #(.SLOT_CYCLES(SLOT_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_en    (out_en),
    .ram_addr  (ram_addr),
    .phase     (phase),
    .slot_idx  (slot_idx),
    .port_mask (pins.port_mask),
    .port_val  (pins.port_val),
    .first_pin (pins.first_pin),
    .disp_on   (cfg_disp_on)
);

// File: tb/vfd_scan_seq_bench.sv
`timescale 1ns/1ps
module vfd_scan_seq_bench;
    localparam int SC = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_slots = 4'd11;
    logic [1:0]  cfg_duty = 2'b11;
    logic        cfg_disp_on = 1'b1;
    logic [4:0]  cfg_dig_start = 5'd0;
    logic [1:0]  cfg_pin_mode = 2'b11;
    logic [2:0]  cfg_port = 3'b000;
    logic [24:0] ram_rdata = '0;
    logic [5:0]  ram_addr;
    logic [24:0] out_en;

    logic [24:0] mem [16];

    int    n_chk = 0;
    int    n_fail = 0;
    bit    running = 0;
    bit    done = 0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    vfd_scan_seq #(.SLOT_CYCLES(SC)) u_vfd_scan_seq (
        .clk(clk), .rst(rst), .cfg_slots(cfg_slots), .cfg_duty(cfg_duty),
        .cfg_disp_on(cfg_disp_on), .cfg_dig_start(cfg_dig_start),
        .cfg_pin_mode(cfg_pin_mode), .cfg_port(cfg_port),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .out_en(out_en)
    );

    // Synchronous display RAM, one clock of read latency (R4).
    always @(posedge clk) ram_rdata <= mem[ram_addr[5:2]];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: behavioural, driven from the requirement text.
    int          m_idx = 0;
    int          m_ph  = SC - 1;
    logic [24:0] m_pat = '0;
    logic [24:0] m_rd  = '0;
    logic [24:0] m_out = '0;

    function automatic logic [24:0] ref_out(int idx, int ph, logic [24:0] pat);
        logic [24:0] r;
        int pc, first, on16, off, bitn;
        bit lit;
        pc    = (cfg_pin_mode == 2'b00) ? 1 : (cfg_pin_mode == 2'b01) ? 2 :
                (cfg_pin_mode == 2'b10) ? 3 : 0;
        first = (cfg_dig_start > 5'd10) ? 8 : 18 - int'(cfg_dig_start);
        on16  = (cfg_duty == 2'b11) ? 15 : (cfg_duty == 2'b10) ? 6 :
                (cfg_duty == 2'b01) ? 4 : 3;
        off   = (SC / 16) * (16 - on16);
        lit   = cfg_disp_on && (ph >= off);
        for (int i = 0; i < 25; i++) begin
            if (i >= 25 - pc) begin
                bitn = 24 - i;
                r[i] = cfg_port[bitn];
            end else if (!lit)
                r[i] = 1'b0;
            else if (i >= first)
                r[i] = (i == first + idx);
            else
                r[i] = pat[i];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        int old_idx;
        logic [24:0] nout;
        old_idx = m_idx;
        if (rst) begin
            m_idx = 0;
            m_ph  = SC - 1;
            m_pat = '0;
            m_out = '0;
        end else begin
            nout = ref_out(m_idx, m_ph, m_pat);
            if (m_ph == 1) m_pat = m_rd;
            if (m_ph == SC - 1) begin
                m_ph = 0;
                if (m_idx == 0)
                    m_idx = (cfg_slots > 4'd11) ? 4 : 15 - int'(cfg_slots);
                else
                    m_idx = m_idx - 1;
            end else begin
                m_ph = m_ph + 1;
            end
            m_out = nout;
        end
        m_rd = mem[old_idx];
    end

    always @(negedge clk) begin
        if (running && !rst) begin
            check(out_en === m_out, cur_req, "out_en", 32'(out_en), 32'(m_out));
            check(ram_addr === 6'(4 * m_idx), "R4", "ram_addr", 32'(ram_addr), 32'(4 * m_idx));
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < 16; k++)
            mem[k] = 25'((32'h9E3779B9 * (k + seed)) >> 5);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        fill(1);
        // R1: outputs dark during reset
        repeat (3) begin
            @(negedge clk);
            check(out_en == '0, "R1", "out_en in reset", 32'(out_en), 32'h0);
        end
        rst = 1'b0;
        running = 1;

        cur_req = "R2"; run(5 * SC * 2 + 10);

        cur_req = "R5";
        cfg_duty = 2'b00; run(5 * SC);
        cfg_duty = 2'b10; run(5 * SC);
        cfg_duty = 2'b01; run(5 * SC);
        cfg_duty = 2'b11;

        cur_req = "R3";
        cfg_slots = 4'd0;  run(16 * SC * 2 + 17);
        cfg_slots = 4'd14; run(16 * SC + 5 * SC * 2 + 9);
        cfg_slots = 4'd4;  run(12 * SC * 2 + 31);

        cur_req = "R4";
        fill(7); run(12 * SC + 13);
        fill(3); run(12 * SC);

        cfg_slots = 4'd0;
        cur_req = "R6";
        cfg_dig_start = 5'd10; run(16 * SC + 5);
        cfg_dig_start = 5'd3;  run(16 * SC);
        cfg_dig_start = 5'd20; run(16 * SC);

        cur_req = "R7";
        cfg_dig_start = 5'd0;  run(16 * SC * 2);

        cur_req = "R8";
        cfg_port = 3'b101;
        cfg_pin_mode = 2'b00; run(16 * SC);
        cfg_pin_mode = 2'b01; run(16 * SC);
        cfg_pin_mode = 2'b10; run(16 * SC);

        cur_req = "R9";
        for (int i = 0; i < 48; i++) begin
            cfg_port = 3'(i);
            run(7);
        end

        cur_req = "R10";
        cfg_pin_mode = 2'b01;
        cfg_disp_on = 1'b0; run(2 * SC);
        cfg_port = 3'b011;  run(SC);
        cfg_disp_on = 1'b1; run(2 * SC);

        // R1: reset in mid-scan darkens everything
        rst = 1'b1;
        @(negedge clk);
        check(out_en == '0, "R1", "out_en after mid-run reset", 32'(out_en), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R2";
        run(3 * SC);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule